// File: doc/BRIEF.md
# Command Phase Busy Status Tracker

This block follows a disk controller command through its command, result and idle phases. It drives the busy bits of the main status register: one command-busy bit and one busy bit for each drive. Each time the host interface accepts a command byte it sends a one-cycle strobe. With the first byte, the opcode, it also supplies the number of parameter bytes that follow and a flag that says whether the command has a result phase. The tracker counts the parameter bytes. After the last one it either goes back to idle, for commands with no result phase such as seek and recalibrate, or moves to the result phase. It leaves the result phase on a strobe that marks the last result byte as read.

The direction bit tells the host which way the next transfer goes. It reads 0 while bytes flow from host to controller and 1 in the result phase. The drive-busy bits have their own logic. A seek-start strobe with a 2-bit drive select sets one bit. That drive's seek-complete pulse clears it again, so a drive stays busy after command busy has dropped. Opcode decoding, step pulse generation and the host bus belong to other blocks.

Top module: `cmd_busy_tracker`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows `cmd_busy`=0, `dir_out`=0 and all `drv_busy` bits 0.
- R2: An opcode byte (`byte_acc` while idle) with `param_cnt`>0 or `has_result`=1 sets `cmd_busy` in the following cycle.
- R3: For a command with `has_result`=0, `cmd_busy` reads 0 in the cycle after the strobe of parameter byte number `param_cnt`. It stays 1 after each earlier parameter byte.
- R4: For a command with `has_result`=1, `dir_out` becomes 1 after the last parameter byte, or right after the opcode when `param_cnt`=0. `cmd_busy` stays 1 until the cycle after `res_done`, and then both bits read 0.
- R5: `dir_out` is 0 while the parameter bytes are being accepted.
- R6: An opcode with `param_cnt`=0 and `has_result`=0 leaves `cmd_busy` at 0.
- R7: `seek_start` sets `drv_busy[seek_sel]` in the next cycle (the bit index is the 2-bit select value) and leaves the other drive bits unchanged.
- R8: `seek_done[i]` clears `drv_busy[i]` in the next cycle, whatever the state of `cmd_busy`.
- R9: If `seek_start` selects drive i in the same cycle as `seek_done[i]`, the bit is 1 in the next cycle.
- R10: `byte_acc` has no effect in the result phase, and `res_done` has no effect outside it.
- R11: `param_cnt` and `has_result` are sampled only with the opcode byte. Their values at later byte strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_acc | input | 1 | One-cycle strobe: a command byte was accepted |
| param_cnt | input | CNT_W | Number of parameter bytes after the opcode (valid with the opcode) |
| has_result | input | 1 | The command has a result phase (valid with the opcode) |
| res_done | input | 1 | One-cycle strobe: the last result byte has been read |
| seek_start | input | 1 | Strobe: the selected drive begins a seek or recalibrate |
| seek_sel | input | DRV_W | Drive select for `seek_start` |
| seek_done | input | NUM_DRV | Per-drive seek-complete pulses |
| cmd_busy | output | 1 | A command is in progress |
| dir_out | output | 1 | Transfer direction: 0 host-to-controller, 1 result phase |
| drv_busy | output | NUM_DRV | Per-drive seek busy |

## Verification
Every output is registered, so each result is due exactly one clock edge after the strobe that causes it. The bench changes inputs on the falling edge, and a strobe lasts until the next falling edge. The outputs are therefore sampled at that falling edge, half a cycle after the edge that captured the strobe. The sweep covers every parameter count from 0 to 7 with and without a result phase, and checks both bits after every byte. Drive tests set and clear every drive one at a time, including a start and a done for the same drive in one cycle, and run while a command is busy.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int NUM_DRV_D = 4;
    localparam int CNT_W_D   = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_RES  = 2'd2
    } phase_e;

    typedef struct packed {
        logic busy;
        logic dir;
    } cmd_stat_t;

    function automatic cmd_stat_t stat_of(input phase_e ph);
        cmd_stat_t s;
        s.busy = (ph != PH_IDLE);
        s.dir  = (ph == PH_RES);
        return s;
    endfunction
endpackage

// File: rtl/cbt_phase_fsm.sv
module cbt_phase_fsm
    import cbt_pkg::*;
#(
    parameter int CNT_W = CNT_W_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_acc,
    input  logic [CNT_W-1:0] param_cnt,
    input  logic             has_result,
    input  logic             res_done,
    output cmd_stat_t        stat
);
    phase_e           phase_q;
    logic [CNT_W-1:0] remain_q;
    logic             want_res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            remain_q   <= '0;
            want_res_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (byte_acc) begin
                        if (param_cnt != '0) begin
                            phase_q    <= PH_CMD;
                            remain_q   <= param_cnt;
                            want_res_q <= has_result;
                        end else if (has_result) begin
                            phase_q <= PH_RES;
                        end
                    end
                end
                PH_CMD: begin
                    if (byte_acc) begin
                        if (remain_q == CNT_W'(1)) begin
                            phase_q  <= want_res_q ? PH_RES : PH_IDLE;
                            remain_q <= '0;
                        end else begin
                            remain_q <= remain_q - CNT_W'(1);
                        end
                    end
                end
                PH_RES: begin
                    if (res_done) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign stat = stat_of(phase_q);
endmodule

// File: rtl/cbt_drive_bank.sv
module cbt_drive_bank #(
    parameter int NUM_DRV = 4,
    parameter int DRV_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               seek_start,
    input  logic [DRV_W-1:0]   seek_sel,
    input  logic [NUM_DRV-1:0] seek_done,
    output logic [NUM_DRV-1:0] busy
);
    for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
        logic hit;
        assign hit = seek_start && (seek_sel == DRV_W'(i));
        always_ff @(posedge clk) begin
            if (rst)               busy[i] <= 1'b0;
            else if (hit)          busy[i] <= 1'b1;
            else if (seek_done[i]) busy[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_busy_tracker.sv
module cmd_busy_tracker
    import cbt_pkg::*;
#(
    parameter int NUM_DRV = NUM_DRV_D,
    parameter int CNT_W   = CNT_W_D,
    localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_acc,
    input  logic [CNT_W-1:0]   param_cnt,
    input  logic               has_result,
    input  logic               res_done,
    input  logic               seek_start,
    input  logic [DRV_W-1:0]   seek_sel,
    input  logic [NUM_DRV-1:0] seek_done,
    output logic               cmd_busy,
    output logic               dir_out,
    output logic [NUM_DRV-1:0] drv_busy
);
    cmd_stat_t stat;

    cbt_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .byte_acc   (byte_acc),
        .param_cnt  (param_cnt),
        .has_result (has_result),
        .res_done   (res_done),
        .stat       (stat)
    );

    cbt_drive_bank #(.NUM_DRV(NUM_DRV), .DRV_W(DRV_W)) u_drv (
        .clk        (clk),
        .rst        (rst),
        .seek_start (seek_start),
        .seek_sel   (seek_sel),
        .seek_done  (seek_done),
        .busy       (drv_busy)
    );

    assign cmd_busy = stat.busy;
    assign dir_out  = stat.dir;
endmodule

// File: rtl/cbt_chk.sv
module cbt_chk #(
    parameter int NUM_DRV = 4,
    parameter int CNT_W   = 4,
    parameter int DRV_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               byte_acc,
    input logic [CNT_W-1:0]   param_cnt,
    input logic               has_result,
    input logic               res_done,
    input logic               seek_start,
    input logic [DRV_W-1:0]   seek_sel,
    input logic [NUM_DRV-1:0] seek_done,
    input logic               cmd_busy,
    input logic               dir_out,
    input logic [NUM_DRV-1:0] drv_busy
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!cmd_busy && !dir_out && drv_busy == '0));

    // R2
    opcode_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_acc && !cmd_busy && (param_cnt != '0 || has_result)) |=> cmd_busy);

    // R6
    bare_opcode_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_acc && !cmd_busy && param_cnt == '0 && !has_result) |=> !cmd_busy);

    // R4
    dir_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
        dir_out |-> cmd_busy);

    // R10
    result_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_out && !res_done) |=> (dir_out && cmd_busy));

    // R4
    result_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_out && res_done) |=> (!dir_out && !cmd_busy));

    // R7
    seek_sets_chk: assert property (@(posedge clk) disable iff (rst)
        seek_start |=> drv_busy[$past(seek_sel)]);

    for (genvar i = 0; i < NUM_DRV; i++) begin : g_chk
        // R8
        seek_done_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (seek_done[i] && !(seek_start && seek_sel == DRV_W'(i))) |=> !drv_busy[i]);
        // R7
        other_drive_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (!seek_done[i] && !(seek_start && seek_sel == DRV_W'(i))) |=> $stable(drv_busy[i]));
    end
endmodule

bind cmd_busy_tracker cbt_chk #(.NUM_DRV(NUM_DRV), .CNT_W(CNT_W), .DRV_W(DRV_W)) u_chk (.*);

// File: tb/cmd_busy_tracker_tb.sv
module cmd_busy_tracker_tb;
    localparam int NUM_DRV = 4;
    localparam int CNT_W   = 4;
    localparam int DRV_W   = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               byte_acc = 1'b0;
    logic [CNT_W-1:0]   param_cnt = '0;
    logic               has_result = 1'b0;
    logic               res_done = 1'b0;
    logic               seek_start = 1'b0;
    logic [DRV_W-1:0]   seek_sel = '0;
    logic [NUM_DRV-1:0] seek_done = '0;
    logic               cmd_busy;
    logic               dir_out;
    logic [NUM_DRV-1:0] drv_busy;

    int checks = 0;
    int errors = 0;
    logic [NUM_DRV-1:0] exp_drv = '0;

    always #2 clk = ~clk;

    cmd_busy_tracker u_dut (
        .clk(clk), .rst(rst), .byte_acc(byte_acc), .param_cnt(param_cnt),
        .has_result(has_result), .res_done(res_done), .seek_start(seek_start),
        .seek_sel(seek_sel), .seek_done(seek_done), .cmd_busy(cmd_busy),
        .dir_out(dir_out), .drv_busy(drv_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_byte(input int pc, input logic hr);
        @(negedge clk);
        byte_acc = 1'b1; param_cnt = CNT_W'(pc); has_result = hr;
        @(negedge clk);
        byte_acc = 1'b0; param_cnt = '0; has_result = 1'b0;
    endtask

    task automatic pulse_res;
        @(negedge clk); res_done = 1'b1;
        @(negedge clk); res_done = 1'b0;
    endtask

    task automatic seek(input logic st, input int sel, input logic [NUM_DRV-1:0] dn);
        @(negedge clk);
        seek_start = st; seek_sel = DRV_W'(sel); seek_done = dn;
        @(negedge clk);
        seek_start = 1'b0; seek_done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 cmd_busy", cmd_busy, 0);
        check("R1 dir_out", dir_out, 0);
        check("R1 drv_busy", drv_busy, 0);

        // command sweep: every parameter count with and without result phase
        for (int pc = 0; pc < 8; pc++) begin
            for (int hr = 0; hr < 2; hr++) begin
                send_byte(pc, hr[0]);
                if (pc == 0 && hr == 0)
                    check("R6 no-op opcode", cmd_busy, 0);
                else
                    check("R2 busy after opcode", cmd_busy, 1);
                check(pc == 0 ? "R4 dir after opcode" : "R5 dir in command",
                      dir_out, (pc == 0 && hr == 1) ? 1 : 0);
                for (int k = 1; k <= pc; k++) begin
                    // R11: garbage count and flag on parameter bytes
                    send_byte((pc + 3) % 8, ~hr[0]);
                    check(hr == 0 ? "R3 busy after param" : "R4 busy after param",
                          cmd_busy, (k < pc || hr == 1) ? 1 : 0);
                    check(k < pc ? "R5 dir during params" : "R4 dir at end",
                          dir_out, (k == pc && hr == 1) ? 1 : 0);
                end
                if (hr == 1) begin
                    send_byte(2, 1'b0);
                    check("R10 byte in result phase busy", cmd_busy, 1);
                    check("R10 byte in result phase dir", dir_out, 1);
                    pulse_res();
                    check("R4 busy after res_done", cmd_busy, 0);
                    check("R4 dir after res_done", dir_out, 0);
                end
            end
        end

        // res_done outside the result phase
        pulse_res();
        check("R10 res_done idle", cmd_busy, 0);
        send_byte(2, 1'b1);
        pulse_res();
        check("R10 res_done in command busy", cmd_busy, 1);
        check("R10 res_done in command dir", dir_out, 0);
        send_byte(0, 1'b0);
        send_byte(0, 1'b0);
        check("R4 result after params", dir_out, 1);
        pulse_res();
        check("R4 cleared", cmd_busy, 0);

        // R11: count taken from opcode, not later strobes
        send_byte(1, 1'b0);
        send_byte(7, 1'b1);
        check("R11 count latched", cmd_busy, 0);

        // drive bits: set each in turn
        for (int d = 0; d < NUM_DRV; d++) begin
            seek(1'b1, d, '0);
            exp_drv = exp_drv | (NUM_DRV'(1) << d);
            check("R7 seek start", drv_busy, exp_drv);
        end
        // clear each while a command holds busy
        send_byte(3, 1'b1);
        for (int d = 0; d < NUM_DRV; d++) begin
            seek(1'b0, 0, NUM_DRV'(1) << d);
            exp_drv = exp_drv & ~(NUM_DRV'(1) << d);
            check("R8 seek done", drv_busy, exp_drv);
            check("R8 cmd busy unaffected", cmd_busy, 1);
        end
        // simultaneous start and done, same drive and different drive
        for (int d = 0; d < NUM_DRV; d++) begin
            seek(1'b1, d, NUM_DRV'(1) << d);
            exp_drv = exp_drv | (NUM_DRV'(1) << d);
            check("R9 start wins", drv_busy, exp_drv);
            seek(1'b1, d, NUM_DRV'(1) << ((d + 1) % NUM_DRV));
            exp_drv = (exp_drv & ~(NUM_DRV'(1) << ((d + 1) % NUM_DRV))) | (NUM_DRV'(1) << d);
            check("R8 done other drive", drv_busy, exp_drv);
        end
        // finish the command: drive bits outlive it
        send_byte(0, 1'b0); send_byte(0, 1'b0); send_byte(0, 1'b0);
        pulse_res();
        check("R8 drive busy outlives command", drv_busy, exp_drv);
        check("R4 command clear", cmd_busy, 0);

        // reset mid-activity
        send_byte(2, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 busy after reset", cmd_busy, 0);
        check("R1 drives after reset", drv_busy, 0);
        check("R1 dir after reset", dir_out, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule